// File: doc/BRIEF.md
# Serial Controller Write Sequencer

This block is the host-side control port of a programmable serial controller. The host reaches it over a byte-wide bus. A select input picks either the control location or the data location. The separate transmitter and receiver engines are steered by the configuration and command state that this block keeps. It also reads their flags back as one status byte.

All control writes go to the same location, and their meaning depends on the order they arrive in. The first control write after a reset is the format word. It holds the clock divider, the character length, the parity controls, and the stop-length or sync options. If that format word chose synchronous operation, the next one or two control writes are stored as sync characters. Every control write after that is a command word. A command word sets the enables and the modem lines, fires one-cycle strobes for break-free error clearing and sync hunting, or hands control back to the format-word step.

Writes to the data location are passed to the transmitter as a one-cycle load strobe with the byte. Reads return the status byte when the control location is selected and the received byte otherwise.

Top module: `sersq_top`

## Requirements
- R1: After the reset input, the next control write is the format word. Both enables, the break force and all strobes are 0. The format outputs and both sync characters are 0. The DTR and RTS pins are at their deasserted level, which is 1 with the default active-low polarity.
- R2: A format write latches its fields: divider from bits 1:0, character length from bits 3:2, parity enable from bit 4, even parity from bit 5, and stop length from bits 7:6. The same bits 7:6 are also shown as ext_sync (bit 6) and single_sync (bit 7).
- R3: A format word with a nonzero divider (asynchronous) makes the very next control write a command word.
- R4: A format word with divider 0 and bit 7 clear makes the next two control writes sync character 1 and sync character 2, in that order. The write after them is a command word.
- R5: A format word with divider 0 and bit 7 set makes the next control write sync character 1 only. The write after it is a command word, and sync character 2 is left unchanged.
- R6: A command word sets tx_en from bit 0, DTR from bit 1, rx_en from bit 2, brk_force from bit 3 and RTS from bit 5. These values hold until the next command word.
- R7: Command bit 4 gives err_clr high for exactly the one cycle after the write.
- R8: Command bit 6 clears tx_en, rx_en, brk_force, DTR and RTS. The rest of that word is ignored and no strobes are fired. The format fields are kept, and the next control write is again a format word.
- R9: Command bit 7 gives hunt_req high for one cycle only when the latched divider is 0. In asynchronous mode the bit has no effect.
- R10: The status byte holds, from bit 0 up: tx_rdy, rx_rdy, tx_empty, par_err, ovr_err, frm_err, syn_brk, and DSR asserted. DSR is asserted when dsr_pin is 0 with the default polarity. Status follows its inputs with no delay.
- R11: rd_data equals the status byte while sel_ctrl is 1 and equals rx_byte while sel_ctrl is 0.
- R12: A data write (wr_en with sel_ctrl 0) gives tx_wr high for one cycle and registers the byte on tx_byte. It does not advance or change the control write sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| sel_ctrl | input | 1 | 1 selects the control/status location, 0 the data location |
| wr_data | input | 8 | Write data |
| rx_byte | input | 8 | Received byte from the receiver |
| tx_rdy | input | 1 | Transmitter holding register free |
| rx_rdy | input | 1 | Receiver has a byte |
| tx_empty | input | 1 | Transmitter fully idle |
| par_err | input | 1 | Parity error flag |
| ovr_err | input | 1 | Overrun error flag |
| frm_err | input | 1 | Framing error flag |
| syn_brk | input | 1 | Sync or break detect flag |
| dsr_pin | input | 1 | Data-set-ready pin |
| rd_data | output | 8 | Read data |
| status | output | 8 | Assembled status byte |
| tx_wr | output | 1 | One-cycle load strobe to the transmitter |
| tx_byte | output | 8 | Byte for the transmitter |
| tx_en | output | 1 | Transmit enable |
| rx_en | output | 1 | Receive enable |
| brk_force | output | 1 | Hold the serial output low |
| err_clr | output | 1 | One-cycle error-flag clear strobe |
| hunt_req | output | 1 | One-cycle sync hunt request |
| dtr_pin | output | 1 | Data-terminal-ready pin |
| rts_pin | output | 1 | Request-to-send pin |
| clk_div | output | 2 | Divider code, 0 = synchronous |
| char_len | output | 2 | Character length code, 0..3 = 5..8 bits |
| par_en | output | 1 | Parity enable |
| par_even | output | 1 | Even parity when 1 |
| stop_len | output | 2 | Stop length code |
| ext_sync | output | 1 | External sync detect (synchronous mode) |
| single_sync | output | 1 | Single sync character (synchronous mode) |
| sync_chr1 | output | 8 | First sync character |
| sync_chr2 | output | 8 | Second sync character |

## Verification
The bench builds the block with its default parameter, PIN_ACT_LOW = 1, so the modem pins are active low. With that setting the bench can check that DTR and RTS idle high after both kinds of reset, and that a low dsr_pin shows up as a set top bit in the status byte. The single build runs through all three paths of the control sequence: asynchronous, double sync and single sync. It also covers the hand-back to the format step and data writes that arrive while a format word is awaited.

// File: rtl/sersq_pkg.sv
package sersq_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned DIV_W  = 2;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        PH_MODE  = 2'd0,
        PH_SYNC1 = 2'd1,
        PH_SYNC2 = 2'd2,
        PH_CMD   = 2'd3
    } phase_e;

    // format word, bit 7 down to bit 0
    typedef struct packed {
        logic [1:0]       tail;      // stop length, or {single, ext} when synchronous
        logic             par_even;
        logic             par_en;
        logic [1:0]       len;
        logic [DIV_W-1:0] div;
    } mode_t;

    // command word, bit 7 down to bit 0
    typedef struct packed {
        logic hunt;
        logic soft_rst;
        logic rts;
        logic err_clr;
        logic brk;
        logic rx_en;
        logic dtr;
        logic tx_en;
    } cmd_t;

    // status byte, bit 7 down to bit 0
    typedef struct packed {
        logic dsr;
        logic syn_brk;
        logic frm_err;
        logic ovr_err;
        logic par_err;
        logic tx_empty;
        logic rx_rdy;
        logic tx_rdy;
    } stat_t;

    localparam mode_t MODE_RST = '0;

    function automatic logic is_sync(mode_t m);
        return m.div == '0;
    endfunction

    function automatic logic wants_one_sync(mode_t m);
        return m.tail[1];
    endfunction

endpackage

// File: rtl/sersq_seq.sv
module sersq_seq
    import sersq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ctrl_wr,
    input  logic   wr_sync_sel,   // incoming format word selects synchronous mode
    input  logic   wr_soft_rst,   // incoming command word requests internal reset
    input  logic   one_sync,      // latched format asks for one sync character
    output phase_e phase,
    output logic   ld_mode,
    output logic   ld_sync1,
    output logic   ld_sync2,
    output logic   ld_cmd
);

    phase_e phase_nx;

    always_comb begin
        ld_mode  = ctrl_wr && (phase == PH_MODE);
        ld_sync1 = ctrl_wr && (phase == PH_SYNC1);
        ld_sync2 = ctrl_wr && (phase == PH_SYNC2);
        ld_cmd   = ctrl_wr && (phase == PH_CMD);
    end

    always_comb begin
        phase_nx = phase;
        if (ctrl_wr) begin
            unique case (phase)
                PH_MODE:  phase_nx = wr_sync_sel ? PH_SYNC1 : PH_CMD;
                PH_SYNC1: phase_nx = one_sync ? PH_CMD : PH_SYNC2;
                PH_SYNC2: phase_nx = PH_CMD;
                PH_CMD:   phase_nx = wr_soft_rst ? PH_MODE : PH_CMD;
                default:  phase_nx = PH_MODE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_MODE;
        else     phase <= phase_nx;
    end

endmodule

// File: rtl/sersq_cfg.sv
module sersq_cfg
    import sersq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ld_mode,
    input  logic  ld_sync1,
    input  logic  ld_sync2,
    input  byte_t wr_data,
    output mode_t mode_q,
    output byte_t sync1_q,
    output byte_t sync2_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_RST;
            sync1_q <= '0;
            sync2_q <= '0;
        end else begin
            if (ld_mode)  mode_q  <= mode_t'(wr_data);
            if (ld_sync1) sync1_q <= wr_data;
            if (ld_sync2) sync2_q <= wr_data;
        end
    end

endmodule

// File: rtl/sersq_cmd.sv
module sersq_cmd
    import sersq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ld_cmd,
    input  byte_t wr_data,
    input  logic  sync_mode,
    output logic  tx_en,
    output logic  rx_en,
    output logic  dtr_act,
    output logic  rts_act,
    output logic  brk_force,
    output logic  err_clr,
    output logic  hunt_req
);

    cmd_t c;
    assign c = cmd_t'(wr_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_en     <= 1'b0;
            rx_en     <= 1'b0;
            dtr_act   <= 1'b0;
            rts_act   <= 1'b0;
            brk_force <= 1'b0;
            err_clr   <= 1'b0;
            hunt_req  <= 1'b0;
        end else begin
            err_clr  <= 1'b0;
            hunt_req <= 1'b0;
            if (ld_cmd) begin
                if (c.soft_rst) begin
                    tx_en     <= 1'b0;
                    rx_en     <= 1'b0;
                    dtr_act   <= 1'b0;
                    rts_act   <= 1'b0;
                    brk_force <= 1'b0;
                end else begin
                    tx_en     <= c.tx_en;
                    rx_en     <= c.rx_en;
                    dtr_act   <= c.dtr;
                    rts_act   <= c.rts;
                    brk_force <= c.brk;
                    err_clr   <= c.err_clr;
                    hunt_req  <= c.hunt && sync_mode;
                end
            end
        end
    end

endmodule

// File: rtl/sersq_stat.sv
module sersq_stat
    import sersq_pkg::*;
(
    input  logic  sel_ctrl,
    input  logic  tx_rdy,
    input  logic  rx_rdy,
    input  logic  tx_empty,
    input  logic  par_err,
    input  logic  ovr_err,
    input  logic  frm_err,
    input  logic  syn_brk,
    input  logic  dsr_act,
    input  byte_t rx_byte,
    output byte_t status,
    output byte_t rd_data
);

    stat_t s;

    always_comb begin
        s.tx_rdy   = tx_rdy;
        s.rx_rdy   = rx_rdy;
        s.tx_empty = tx_empty;
        s.par_err  = par_err;
        s.ovr_err  = ovr_err;
        s.frm_err  = frm_err;
        s.syn_brk  = syn_brk;
        s.dsr      = dsr_act;
        status     = byte_t'(s);
        rd_data    = sel_ctrl ? status : rx_byte;
    end

endmodule

// File: rtl/sersq_top.sv
module sersq_top
    import sersq_pkg::*;
#(
    parameter bit PIN_ACT_LOW = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       sel_ctrl,
    input  logic [7:0] wr_data,
    input  logic [7:0] rx_byte,
    input  logic       tx_rdy,
    input  logic       rx_rdy,
    input  logic       tx_empty,
    input  logic       par_err,
    input  logic       ovr_err,
    input  logic       frm_err,
    input  logic       syn_brk,
    input  logic       dsr_pin,
    output logic [7:0] rd_data,
    output logic [7:0] status,
    output logic       tx_wr,
    output logic [7:0] tx_byte,
    output logic       tx_en,
    output logic       rx_en,
    output logic       brk_force,
    output logic       err_clr,
    output logic       hunt_req,
    output logic       dtr_pin,
    output logic       rts_pin,
    output logic [1:0] clk_div,
    output logic [1:0] char_len,
    output logic       par_en,
    output logic       par_even,
    output logic [1:0] stop_len,
    output logic       ext_sync,
    output logic       single_sync,
    output logic [7:0] sync_chr1,
    output logic [7:0] sync_chr2
);

    logic   ctrl_wr, data_wr;
    logic   ld_mode, ld_sync1, ld_sync2, ld_cmd;
    logic   dtr_act, rts_act, dsr_act;
    phase_e phase;
    mode_t  mode_q;
    mode_t  wr_mode;
    cmd_t   wr_cmd;

    assign ctrl_wr = wr_en && sel_ctrl;
    assign data_wr = wr_en && !sel_ctrl;
    assign wr_mode = mode_t'(wr_data);
    assign wr_cmd  = cmd_t'(wr_data);

    sersq_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .ctrl_wr     (ctrl_wr),
        .wr_sync_sel (is_sync(wr_mode)),
        .wr_soft_rst (wr_cmd.soft_rst),
        .one_sync    (wants_one_sync(mode_q)),
        .phase       (phase),
        .ld_mode     (ld_mode),
        .ld_sync1    (ld_sync1),
        .ld_sync2    (ld_sync2),
        .ld_cmd      (ld_cmd)
    );

    sersq_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .ld_mode  (ld_mode),
        .ld_sync1 (ld_sync1),
        .ld_sync2 (ld_sync2),
        .wr_data  (wr_data),
        .mode_q   (mode_q),
        .sync1_q  (sync_chr1),
        .sync2_q  (sync_chr2)
    );

    sersq_cmd u_cmd (
        .clk       (clk),
        .rst       (rst),
        .ld_cmd    (ld_cmd),
        .wr_data   (wr_data),
        .sync_mode (is_sync(mode_q)),
        .tx_en     (tx_en),
        .rx_en     (rx_en),
        .dtr_act   (dtr_act),
        .rts_act   (rts_act),
        .brk_force (brk_force),
        .err_clr   (err_clr),
        .hunt_req  (hunt_req)
    );

    sersq_stat u_stat (
        .sel_ctrl (sel_ctrl),
        .tx_rdy   (tx_rdy),
        .rx_rdy   (rx_rdy),
        .tx_empty (tx_empty),
        .par_err  (par_err),
        .ovr_err  (ovr_err),
        .frm_err  (frm_err),
        .syn_brk  (syn_brk),
        .dsr_act  (dsr_act),
        .rx_byte  (rx_byte),
        .status   (status),
        .rd_data  (rd_data)
    );

    // pin polarity variant
    generate
        if (PIN_ACT_LOW) begin : g_pin_low
            assign dtr_pin = ~dtr_act;
            assign rts_pin = ~rts_act;
            assign dsr_act = ~dsr_pin;
        end else begin : g_pin_high
            assign dtr_pin = dtr_act;
            assign rts_pin = rts_act;
            assign dsr_act = dsr_pin;
        end
    endgenerate

    // transmitter load path
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_wr   <= 1'b0;
            tx_byte <= '0;
        end else begin
            tx_wr <= data_wr;
            if (data_wr) tx_byte <= wr_data;
        end
    end

    assign clk_div     = mode_q.div;
    assign char_len    = mode_q.len;
    assign par_en      = mode_q.par_en;
    assign par_even    = mode_q.par_even;
    assign stop_len    = mode_q.tail;
    assign ext_sync    = mode_q.tail[0];
    assign single_sync = mode_q.tail[1];

    logic phase_unused;
    assign phase_unused = ^phase;

endmodule

// File: rtl/sersq_chk.sv
module sersq_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       sel_ctrl,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic [7:0] status,
    input logic       tx_wr,
    input logic [7:0] tx_byte,
    input logic       tx_en,
    input logic       err_clr,
    input logic       hunt_req,
    input logic [1:0] clk_div
);

    // R6
    tx_en_src_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(tx_en) |-> $past(wr_en && sel_ctrl));

    // R7
    err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        err_clr |-> $past(wr_en && sel_ctrl && wr_data[4]));

    // R9
    hunt_sync_chk: assert property (@(posedge clk) disable iff (rst)
        hunt_req |-> (clk_div == 2'd0) && $past(wr_en && sel_ctrl && wr_data[7]));

    // R11
    rd_mux_chk: assert property (@(posedge clk) disable iff (rst)
        sel_ctrl |-> (rd_data == status));

    // R12
    tx_load_chk: assert property (@(posedge clk) disable iff (rst)
        tx_wr |-> $past(wr_en && !sel_ctrl) && (tx_byte == $past(wr_data)));

endmodule

bind sersq_top sersq_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .sel_ctrl (sel_ctrl),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .status   (status),
    .tx_wr    (tx_wr),
    .tx_byte  (tx_byte),
    .tx_en    (tx_en),
    .err_clr  (err_clr),
    .hunt_req (hunt_req),
    .clk_div  (clk_div)
);

// File: tb/sersq_top_tb_top.sv
`timescale 1ns/1ps
module sersq_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, sel_ctrl = 1'b0;
    logic [7:0] wr_data = '0, rx_byte = '0;
    logic       tx_rdy = 0, rx_rdy = 0, tx_empty = 0, par_err = 0;
    logic       ovr_err = 0, frm_err = 0, syn_brk = 0, dsr_pin = 1;
    logic [7:0] rd_data, status, tx_byte, sync_chr1, sync_chr2;
    logic       tx_wr, tx_en, rx_en, brk_force, err_clr, hunt_req;
    logic       dtr_pin, rts_pin, par_en, par_even, ext_sync, single_sync;
    logic [1:0] clk_div, char_len, stop_len;

    always #2.5 clk = ~clk;

    sersq_top dut_i (.*);

    int n_run = 0, n_fail = 0;
    bit done = 0;

    typedef logic [41:0] obs_t;
    typedef struct { string tag; obs_t obs; } exp_t;
    exp_t q[$];

    // reference state built from the requirements
    int         m_ph;
    logic [7:0] m_mode, m_s1, m_s2, m_txb;
    logic       m_tx, m_rx, m_dtr, m_rts, m_brk, m_err, m_hunt, m_txwr;

    function automatic obs_t obs_now();
        return {tx_en, rx_en, dtr_pin, rts_pin, brk_force, err_clr, hunt_req, tx_wr,
                clk_div, char_len, par_en, par_even, stop_len, ext_sync, single_sync,
                sync_chr1, sync_chr2, tx_byte};
    endfunction

    function automatic obs_t obs_model();
        return {m_tx, m_rx, ~m_dtr, ~m_rts, m_brk, m_err, m_hunt, m_txwr,
                m_mode[1:0], m_mode[3:2], m_mode[4], m_mode[5], m_mode[7:6],
                m_mode[6], m_mode[7], m_s1, m_s2, m_txb};
    endfunction

    task automatic model_reset();
        m_ph = 0; m_mode = '0; m_s1 = '0; m_s2 = '0; m_txb = '0;
        {m_tx, m_rx, m_dtr, m_rts, m_brk, m_err, m_hunt, m_txwr} = '0;
    endtask

    // monitor: compares registered outputs against queued expectations
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_run++;
                if (obs_now() !== e.obs) begin
                    n_fail++;
                    $display("FAIL %s act=%h exp=%h", e.tag, obs_now(), e.obs);
                end
            end
        end
    end

    task automatic push(string tag);
        exp_t e;
        e.tag = tag;
        e.obs = obs_model();
        q.push_back(e);
    endtask

    // driver: one bus write, then an idle cycle that checks strobe width
    task automatic bus_wr(bit ctl, logic [7:0] d, string tag);
        @(negedge clk);
        wr_en = 1'b1; sel_ctrl = ctl; wr_data = d;
        @(posedge clk);
        m_err = 0; m_hunt = 0; m_txwr = 0;
        if (!ctl) begin
            m_txwr = 1; m_txb = d;
        end else begin
            case (m_ph)
                0: begin m_mode = d; m_ph = (d[1:0] == 2'd0) ? 1 : 3; end
                1: begin m_s1 = d; m_ph = m_mode[7] ? 3 : 2; end
                2: begin m_s2 = d; m_ph = 3; end
                default: begin
                    if (d[6]) begin
                        {m_tx, m_rx, m_dtr, m_rts, m_brk} = '0;
                        m_ph = 0;
                    end else begin
                        m_tx = d[0]; m_dtr = d[1]; m_rx = d[2]; m_brk = d[3];
                        m_err = d[4]; m_rts = d[5];
                        m_hunt = d[7] && (m_mode[1:0] == 2'd0);
                    end
                end
            endcase
        end
        push(tag);
        @(negedge clk);
        wr_en = 1'b0;
        @(posedge clk);
        m_err = 0; m_hunt = 0; m_txwr = 0;
        push({tag, " idle"});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(posedge clk);
        push("R1 reset state");
    endtask

    task automatic chk8(string tag, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic status_case(logic [6:0] flags, logic dpin, logic [7:0] rxb);
        @(negedge clk);
        {syn_brk, frm_err, ovr_err, par_err, tx_empty, rx_rdy, tx_rdy} = flags;
        dsr_pin = dpin; rx_byte = rxb; sel_ctrl = 1'b1;
        #1;
        chk8("R10 status", status, {~dpin, flags});
        chk8("R11 rd_data ctrl", rd_data, {~dpin, flags});
        sel_ctrl = 1'b0;
        #1;
        chk8("R11 rd_data data", rd_data, rxb);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        push("R1 reset state");

        // asynchronous path
        bus_wr(1, 8'hFE, "R2 async format fields");
        bus_wr(1, 8'h27, "R3 R6 first command after async format");
        bus_wr(1, 8'h08, "R6 break only");
        bus_wr(1, 8'h10, "R7 error clear pulse");
        bus_wr(1, 8'h80, "R9 hunt ignored async");
        bus_wr(0, 8'h5A, "R12 data write");
        bus_wr(1, 8'h41, "R8 internal reset ignores other bits");
        bus_wr(0, 8'hA5, "R12 data write while format awaited");
        bus_wr(1, 8'h4D, "R8 R2 new format accepted");
        bus_wr(1, 8'h22, "R3 R6 dtr and rts");

        // double sync path
        bus_wr(1, 8'h40, "R8 internal reset");
        bus_wr(1, 8'h0C, "R4 sync format double");
        bus_wr(1, 8'h16, "R4 sync char 1");
        bus_wr(1, 8'h17, "R4 sync char 2");
        bus_wr(1, 8'h81, "R4 R9 command with hunt");

        // single sync path
        bus_wr(1, 8'h40, "R8 internal reset");
        bus_wr(1, 8'hAC, "R5 R2 sync format single");
        bus_wr(1, 8'h33, "R5 only sync char");
        bus_wr(1, 8'h04, "R5 command after one sync char");
        bus_wr(1, 8'h94, "R7 R9 clear and hunt together");

        // status assembly
        status_case(7'b0000001, 1'b1, 8'h3C);
        status_case(7'b1010110, 1'b0, 8'hC3);
        status_case(7'b1111111, 1'b0, 8'h00);
        status_case(7'b0101000, 1'b1, 8'hFF);

        // hardware reset in mid-run
        bus_wr(1, 8'h23, "R6 before reset");
        do_reset();

        repeat (4) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog act=hung exp=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule